// File: doc/BRIEF.md
# I2C Bus-Hang Recovery Sequencer

This block frees an I2C bus that a transfer cut off halfway has left stuck. It runs once per request at initialisation. It first gives the I2C controller a bounded time to report that the bus has gone idle by itself. If the controller still reports busy when that time runs out, or if the data line reads low, the block takes both bus pins away from the I2C controller and gives them to plain GPIO. It then clocks SCL by hand until the slave that holds SDA lets go, parks SCL high and hands the pins back.

All timing is counted in milliseconds. The milliseconds are built from a microsecond tick that the caller supplies. The number of polls and the number of recovery clocks are parameters. A one-cycle done pulse closes every request. A status bit tells whether SDA was still low when the recovery clocks ran out. Issuing a STOP condition afterwards is left to the I2C controller.

Top module: `busfree_top`

## Requirements
- R1: After reset, scl_o is 1, gpio_sel_o is 0, done_o is 0 and stuck_o is 0.
- R2: If busy_i is 0 and sda_i is 1 just after start_i, the pins are never taken over and done_o pulses within 3 cycles of start_i.
- R3: While busy_i is 1, the block polls once per millisecond for up to POLL_LIMIT ms. If busy_i clears inside that window and sda_i is 1, no recovery takes place.
- R4: If busy_i is still 1 after POLL_LIMIT ms, recovery starts (gpio_sel_o=1), whatever the level of SDA.
- R5: If busy_i is 0 but sda_i reads 0, recovery starts.
- R6: When recovery starts, gpio_sel_o goes to 1 (1 selects GPIO, 0 selects the I2C function) with scl_o low, and scl_o stays low for 1 ms before the first pulse.
- R7: Each recovery pulse drives SCL high for 1 ms and then low for 1 ms. SDA is sampled at the end of every low phase, and pulsing stops as soon as SDA reads 1.
- R8: At most PULSE_LIMIT pulses are issued per recovery.
- R9: After pulsing, SCL is driven high for 1 ms with GPIO still selected. In the next cycle gpio_sel_o returns to 0 and done_o is 1 for exactly that cycle.
- R10: stuck_o becomes 1 when the pulse limit is reached with SDA still low, holds until the next start_i and is cleared by it.
- R11: scl_o is 1 whenever gpio_sel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to check and recover the bus |
| busy_i | input | 1 | Busy flag from the I2C controller |
| sda_i | input | 1 | Level of the SDA pin |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| scl_o | output | 1 | SCL level driven while the pins are in GPIO mode |
| gpio_sel_o | output | 1 | Pin mux select: 1 = GPIO, 0 = I2C function |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| stuck_o | output | 1 | SDA was still low when the pulse limit was reached |

## Verification
The assertions check on every cycle the properties that hold at all times: SCL stays high whenever the pins belong to the I2C controller, a takeover starts with SCL low, the pins return in the same cycle as a single-cycle done pulse, stuck rises only on entry to the park phase, and the number of SCL rises per takeover stays within the limit plus the park edge. Only the bench scenarios can show the counted behaviour. That covers the length of the polling window, the exact count of low and high milliseconds, the point where pulsing stops after the slave lets go, and whether the sequence takes the pins at all for a given mix of busy and SDA levels.

// File: rtl/busfree_pkg.sv
package busfree_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_POLL  = 3'd1,
    ST_PRELO = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4,
    ST_PARK  = 3'd5,
    ST_FIN   = 3'd6
  } bf_state_e;
endpackage

// File: rtl/busfree_ms_timer.sv
module busfree_ms_timer #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic us_tick_i,
  output logic ms_pulse_o
);
  localparam int CW = $clog2(TICKS_PER_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last    = (cnt_q == LAST);
  assign ms_pulse_o = us_tick_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)          cnt_d = '0;
    else if (us_tick_i) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/busfree_counter.sv
module busfree_counter #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_last_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign at_last_o = (cnt_q == LAST);
  assign cnt_en    = clr_i || inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/busfree_fsm.sv
module busfree_fsm
  import busfree_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_i,
  input  logic ms_pulse_i,
  input  logic poll_last_i,
  input  logic pulse_last_i,
  output logic timer_clr_o,
  output logic cnt_clr_o,
  output logic poll_inc_o,
  output logic pulse_inc_o,
  output logic scl_o,
  output logic gpio_sel_o,
  output logic done_o,
  output logic stuck_o
);
  bf_state_e state_q, state_d;
  logic      stuck_q, stuck_d, stuck_en;
  logic      set_stuck;

  always_comb begin
    state_d     = state_q;
    cnt_clr_o   = 1'b0;
    poll_inc_o  = 1'b0;
    pulse_inc_o = 1'b0;
    set_stuck   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_POLL;
        cnt_clr_o = 1'b1;
      end
      ST_POLL: begin
        if (!busy_i) begin
          state_d = sda_i ? ST_FIN : ST_PRELO;
        end else if (ms_pulse_i) begin
          poll_inc_o = 1'b1;
          if (poll_last_i) state_d = ST_PRELO;
        end
      end
      ST_PRELO: if (ms_pulse_i) state_d = sda_i ? ST_PARK : ST_HIGH;
      ST_HIGH:  if (ms_pulse_i) state_d = ST_LOW;
      ST_LOW: if (ms_pulse_i) begin
        pulse_inc_o = 1'b1;
        if (sda_i) begin
          state_d = ST_PARK;
        end else if (pulse_last_i) begin
          state_d   = ST_PARK;
          set_stuck = 1'b1;
        end else begin
          state_d = ST_HIGH;
        end
      end
      ST_PARK: if (ms_pulse_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign timer_clr_o = (state_d != state_q);

  // stuck: cleared by an accepted start, set when pulses run out
  assign stuck_en = cnt_clr_o || set_stuck;
  assign stuck_d  = set_stuck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stuck_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (stuck_en) stuck_q <= stuck_d;
    end
  end

  assign scl_o      = !((state_q == ST_PRELO) || (state_q == ST_LOW));
  assign gpio_sel_o = (state_q == ST_PRELO) || (state_q == ST_HIGH) ||
                      (state_q == ST_LOW)   || (state_q == ST_PARK);
  assign done_o     = (state_q == ST_FIN);
  assign stuck_o    = stuck_q;
endmodule

// File: rtl/busfree_top.sv
module busfree_top #(
  parameter int TICKS_PER_MS = 1000,
  parameter int POLL_LIMIT   = 1000,
  parameter int PULSE_LIMIT  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_i,
  input  logic us_tick_i,
  output logic scl_o,
  output logic gpio_sel_o,
  output logic done_o,
  output logic stuck_o
);
  logic ms_pulse, timer_clr, cnt_clr;
  logic poll_inc, poll_last, pulse_inc, pulse_last;

  busfree_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr),
    .us_tick_i(us_tick_i), .ms_pulse_o(ms_pulse)
  );

  busfree_counter #(.LIMIT(POLL_LIMIT)) u_poll_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr),
    .inc_i(poll_inc), .at_last_o(poll_last)
  );

  busfree_counter #(.LIMIT(PULSE_LIMIT)) u_pulse_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr),
    .inc_i(pulse_inc), .at_last_o(pulse_last)
  );

  busfree_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .sda_i(sda_i), .ms_pulse_i(ms_pulse), .poll_last_i(poll_last),
    .pulse_last_i(pulse_last), .timer_clr_o(timer_clr),
    .cnt_clr_o(cnt_clr), .poll_inc_o(poll_inc), .pulse_inc_o(pulse_inc),
    .scl_o(scl_o), .gpio_sel_o(gpio_sel_o), .done_o(done_o),
    .stuck_o(stuck_o)
  );
endmodule

// File: rtl/busfree_chk.sv
module busfree_chk #(
  parameter int PULSE_LIMIT = 10
) (
  input logic clk,
  input logic rst_n,
  input logic scl_o,
  input logic gpio_sel_o,
  input logic done_o,
  input logic stuck_o
);
  localparam int RW = $clog2(PULSE_LIMIT + 3);
  logic [RW-1:0] rises_q;
  logic          scl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q    <= '0;
      scl_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_o;
      if (!gpio_sel_o)                    rises_q <= '0;
      else if (scl_o && !scl_prev_q)      rises_q <= rises_q + 1'b1;
    end
  end

  assert_scl_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_sel_o |-> scl_o);
  assert_takeover_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpio_sel_o) |-> !scl_o);
  assert_restore_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gpio_sel_o) |-> done_o);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_stuck_at_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_o) |-> (gpio_sel_o && scl_o));
  assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rises_q <= RW'(PULSE_LIMIT + 1));
endmodule

bind busfree_top busfree_chk #(.PULSE_LIMIT(PULSE_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .gpio_sel_o(gpio_sel_o),
  .done_o(done_o), .stuck_o(stuck_o)
);

// File: tb/busfree_top_test.sv
`timescale 1ns/1ps
module busfree_top_test;
  localparam int TPM   = 4;
  localparam int POLLS = 5;
  localparam int PLIM  = 10;

  logic clk = 1'b0;
  logic rst_n, start, busy, us_tick;
  logic scl, gsel, done, stuck;
  logic sda;

  int compared = 0, mismatched = 0;
  int hi_cyc, lo_cyc, rises, falls, done_cnt, done_in_gpio, scl_low_free;
  logic prev_scl = 1'b1;
  bit   hold_low = 1'b0;
  int   release_after = 0;

  always #2.5 clk = ~clk;

  assign sda = !hold_low || (falls >= release_after);

  busfree_top #(.TICKS_PER_MS(TPM), .POLL_LIMIT(POLLS), .PULSE_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy), .sda_i(sda),
    .us_tick_i(us_tick), .scl_o(scl), .gpio_sel_o(gsel), .done_o(done),
    .stuck_o(stuck)
  );

  // observer, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (gsel) begin
      if (scl) hi_cyc++; else lo_cyc++;
      if (scl && !prev_scl) rises++;
      if (!scl && prev_scl) falls++;
    end else if (!scl) scl_low_free++;
    if (done) begin
      done_cnt++;
      if (gsel) done_in_gpio++;
    end
    prev_scl = scl;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit hold, input int rel, input int busy_cycles,
                         output int lat_done, output int lat_gpio);
    @(negedge clk);
    hi_cyc = 0; lo_cyc = 0; rises = 0; falls = 0;
    done_cnt = 0; done_in_gpio = 0; scl_low_free = 0;
    hold_low = hold; release_after = rel;
    busy = (busy_cycles != 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat_done = -1; lat_gpio = -1;
    for (int n = 1; n <= 2000; n++) begin
      if (gsel && lat_gpio < 0) lat_gpio = n;
      if (done) begin lat_done = n; break; end
      if (n == busy_cycles) busy = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    busy = 1'b0; hold_low = 1'b0;
    chk("R9 done seen", (lat_done > 0) ? 1 : 0, 1);
    chk("R9 done one cycle", done_cnt, 1);
    chk("R9 done after restore", done_in_gpio, 0);
    chk("R11 scl high outside gpio", scl_low_free, 0);
  endtask

  task automatic t_reset;
    chk("R1 scl", int'(scl), 1);
    chk("R1 gpio_sel", int'(gsel), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 stuck", int'(stuck), 0);
  endtask

  task automatic t_clean_bus;
    int ld, lg;
    run_seq(1'b0, 0, 0, ld, lg);
    chk("R2 no takeover", lg, -1);
    chk("R2 done latency ok", (ld >= 1 && ld <= 3) ? 1 : 0, 1);
    chk("R10 stuck cleared", int'(stuck), 0);
  endtask

  task automatic t_busy_clears;
    int ld, lg;
    run_seq(1'b0, 0, 2 * TPM + 1, ld, lg);
    chk("R3 no takeover after busy clears", lg, -1);
    chk("R3 waited for busy", (ld > 2 * TPM) ? 1 : 0, 1);
  endtask

  task automatic t_busy_timeout;
    int ld, lg;
    run_seq(1'b0, 0, -1, ld, lg);
    chk("R4 takeover after poll window", (lg >= POLLS * TPM && lg <= POLLS * TPM + 2) ? 1 : 0, 1);
    chk("R6 pre-low length", lo_cyc, TPM);
    chk("R7 no pulses with SDA high", rises, 1);
    chk("R9 park length", hi_cyc, TPM);
    chk("R10 stuck", int'(stuck), 0);
  endtask

  task automatic t_sda_release(input int k);
    int ld, lg;
    run_seq(1'b1, k + 1, 0, ld, lg);
    chk("R5 takeover on SDA low", (lg > 0) ? 1 : 0, 1);
    chk("R7 rises (pulses plus park)", rises, k + 1);
    chk("R6 R7 low cycles", lo_cyc, (k + 1) * TPM);
    chk("R7 R9 high cycles", hi_cyc, (k + 1) * TPM);
    chk("R10 not stuck", int'(stuck), 0);
  endtask

  task automatic t_sda_stuck;
    int ld, lg;
    run_seq(1'b1, 1000, 0, ld, lg);
    chk("R8 rises at limit", rises, PLIM + 1);
    chk("R8 low cycles", lo_cyc, (PLIM + 1) * TPM);
    chk("R10 stuck set", int'(stuck), 1);
    repeat (5) @(negedge clk);
    chk("R10 stuck held", int'(stuck), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; busy = 1'b0; us_tick = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean_bus();
    t_busy_clears();
    t_busy_timeout();
    t_sda_release(1);
    t_sda_release(3);
    t_sda_stuck();
    t_clean_bus();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule